// File: doc/BRIEF.md
# Guest Segment State Consistency Checker

This block decides whether the guest segment-register image offered for a virtual-machine entry is self-consistent. It receives the selector, base, limit and access-rights fields of eight segment registers, the guest flags word, the control that asks for a 64-bit guest, and an extended-feature-enable image together with the control that says whether that image will be loaded. It reports pass or fail and a small code that names the first rule broken.

The block is driven with a one-cycle start pulse. All inputs are captured on that edge, so the caller may change them at once. The rules are evaluated in the next cycle and the result is registered. A one-cycle done pulse follows, and fail and code then hold until the next accepted start. The state machine has three states. IDLE goes to CHECK when start is seen and otherwise stays in IDLE. CHECK always goes to REPORT and registers the verdict on that edge. REPORT always goes back to IDLE and raises done while it lasts.

Segment slot order on every packed input is the same: 0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS, 6 TR, 7 LDTR.

Top module: `guest_seg_checker`

## Requirements
- R1: Start is acted on only in IDLE. If start is high at rising edge N, every input is captured there and done is 1 from edge N+1 to edge N+2 only. Start or input changes after edge N have no effect on that result.
- R2: After reset, done, fail and code are 0. On pass, fail=0 and code=0. On failure, fail=1 and code is nonzero. Fail and code hold until the next accepted start.
- R3: The guest is virtual-8086 when flags bit 17 is 1, and 64-bit when the long-guest control is 1. When both hold, the code is 1.
- R4: When the EFER load control is 1, any set bit under the reserved mask (default 64'hFFFF_FFFF_FFFF_F2FE) gives code 2. Otherwise, bit 8 or bit 10 differing from the long-guest control gives code 3. When the load control is 0, neither rule applies.
- R5: A register is usable when bit 16 of its access rights is 0. A TR selector with bit 2 set gives code 4. A usable LDTR with selector bit 2 set gives code 5.
- R6: When not virtual-8086, SS selector bits 1:0 differing from CS selector bits 1:0 give code 6.
- R7: In virtual-8086 mode, any of CS, SS, DS, ES, FS or GS with a base other than its selector times 16 gives code 7.
- R8: A TR, FS or GS base that is not canonical gives code 8. Canonical means bits 63 down to ADDR_BITS-1 are all equal. The same rule applies to the LDTR base when LDTR is usable.
- R9: Nonzero base bits 63:32 give code 9 for CS always, and for SS, DS or ES when that register is usable.
- R10: In virtual-8086 mode, any of the six data/code limits other than 32'h0000FFFF gives code 10.
- R11: In virtual-8086 mode, any of the six data/code access-rights fields other than 32'h000000F3 gives code 11.
- R12: When several rules are broken, the reported code is the smallest broken code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture inputs and begin a check (IDLE only) |
| seg_sel_i | input | 8x16 | Selectors, slot order CS..LDTR |
| seg_base_i | input | 8x64 | Base addresses |
| seg_limit_i | input | 8x32 | Limits |
| seg_ar_i | input | 8x32 | Access-rights fields |
| guest_flags_i | input | 64 | Guest flags word |
| long_guest_i | input | 1 | 64-bit guest requested |
| efer_load_i | input | 1 | EFER image will be loaded |
| efer_i | input | 64 | EFER image |
| done_o | output | 1 | One-cycle result strobe |
| fail_o | output | 1 | Check failed |
| code_o | output | 5 | First failing rule, 0 on pass |

## Verification
The main sweep covers all eight combinations of virtual-8086, long-guest and EFER-load. Under each combination it applies every subset of twelve single-field corruptions to a clean baseline. Single corruptions show that each rule fires only in the modes where it is enabled. The usability toggles on LDTR and ES show that those rules are switched off rather than merely masked. Multi-fault subsets separate correct priority from mere detection. Directed runs add a start and input changes during CHECK, which shows that the result comes only from the captured image and that done lasts exactly one cycle.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    localparam int NSEG   = 8;
    localparam int SEL_W  = 16;
    localparam int BASE_W = 64;
    localparam int LIM_W  = 32;
    localparam int AR_W   = 32;
    localparam int FLG_W  = 64;
    localparam int CODE_W = 5;
    localparam int NRULE  = 11;
    localparam int NDATA  = 6;   // CS..GS share the virtual-8086 rules

    localparam int SLOT_CS = 0, SLOT_SS = 1, SLOT_DS = 2, SLOT_ES = 3;
    localparam int SLOT_FS = 4, SLOT_GS = 5, SLOT_TR = 6, SLOT_LDTR = 7;

    localparam int FLG_V86_BIT  = 17;
    localparam int AR_UNUSE_BIT = 16;
    localparam int SEL_TI_BIT   = 2;
    localparam int EFER_LME_BIT = 8;
    localparam int EFER_LMA_BIT = 10;

    typedef enum logic [CODE_W-1:0] {
        CHK_OK        = 5'd0,
        CHK_MODE      = 5'd1,
        CHK_EFER_RSVD = 5'd2,
        CHK_EFER_LM   = 5'd3,
        CHK_TR_TI     = 5'd4,
        CHK_LDTR_TI   = 5'd5,
        CHK_SS_RPL    = 5'd6,
        CHK_V86_BASE  = 5'd7,
        CHK_CANON     = 5'd8,
        CHK_HIGH_BASE = 5'd9,
        CHK_V86_LIMIT = 5'd10,
        CHK_V86_AR    = 5'd11
    } chk_code_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_REPORT = 2'd2
    } st_e;
endpackage

// File: rtl/gsc_rule_eval.sv
module gsc_rule_eval
    import gsc_pkg::*;
#(
    parameter int          ADDR_BITS      = 48,
    parameter logic [63:0] EFER_RSVD_MASK = 64'hFFFF_FFFF_FFFF_F2FE
) (
    input  logic [NSEG-1:0][SEL_W-1:0]  sel,
    input  logic [NSEG-1:0][BASE_W-1:0] base,
    input  logic [NSEG-1:0][LIM_W-1:0]  limit,
    input  logic [NSEG-1:0][AR_W-1:0]   ar,
    input  logic                        v86,
    input  logic                        lng,
    input  logic                        efer_load,
    input  logic [63:0]                 efer,
    output logic [NRULE:1]              viol
);
    localparam int HI_LSB = ADDR_BITS - 1;

    logic [NSEG-1:0]  usable, canon, hi_zero;
    logic [NDATA-1:0] base_bad, lim_bad, ar_bad;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign usable[g]  = ~ar[g][AR_UNUSE_BIT];
        assign canon[g]   = (&base[g][BASE_W-1:HI_LSB]) | ~(|base[g][BASE_W-1:HI_LSB]);
        assign hi_zero[g] = ~(|base[g][BASE_W-1:32]);
    end

    for (genvar g = 0; g < NDATA; g++) begin : g_v86
        assign base_bad[g] = base[g] != {{(BASE_W-SEL_W-4){1'b0}}, sel[g], 4'b0000};
        assign lim_bad[g]  = limit[g] != 32'h0000_FFFF;
        assign ar_bad[g]   = ar[g] != 32'h0000_00F3;
    end

    always_comb begin
        viol = '0;
        viol[CHK_MODE]      = v86 & lng;
        viol[CHK_EFER_RSVD] = efer_load & (|(efer & EFER_RSVD_MASK));
        viol[CHK_EFER_LM]   = efer_load & ((efer[EFER_LME_BIT] != lng) | (efer[EFER_LMA_BIT] != lng));
        viol[CHK_TR_TI]     = sel[SLOT_TR][SEL_TI_BIT];
        viol[CHK_LDTR_TI]   = usable[SLOT_LDTR] & sel[SLOT_LDTR][SEL_TI_BIT];
        viol[CHK_SS_RPL]    = ~v86 & (sel[SLOT_SS][1:0] != sel[SLOT_CS][1:0]);
        viol[CHK_V86_BASE]  = v86 & (|base_bad);
        viol[CHK_CANON]     = ~canon[SLOT_TR] | ~canon[SLOT_FS] | ~canon[SLOT_GS]
                            | (usable[SLOT_LDTR] & ~canon[SLOT_LDTR]);
        viol[CHK_HIGH_BASE] = ~hi_zero[SLOT_CS]
                            | (usable[SLOT_SS] & ~hi_zero[SLOT_SS])
                            | (usable[SLOT_DS] & ~hi_zero[SLOT_DS])
                            | (usable[SLOT_ES] & ~hi_zero[SLOT_ES]);
        viol[CHK_V86_LIMIT] = v86 & (|lim_bad);
        viol[CHK_V86_AR]    = v86 & (|ar_bad);
    end
endmodule

// File: rtl/gsc_prio_enc.sv
module gsc_prio_enc
    import gsc_pkg::*;
(
    input  logic [NRULE:1]      viol,
    output logic                any,
    output logic [CODE_W-1:0]   code
);
    always_comb begin
        code = '0;
        for (int i = NRULE; i >= 1; i--) begin
            if (viol[i]) code = CODE_W'(i);
        end
        any = |viol;
    end
endmodule

// File: rtl/guest_seg_checker.sv
module guest_seg_checker
    import gsc_pkg::*;
#(
    parameter int          ADDR_BITS      = 48,
    parameter logic [63:0] EFER_RSVD_MASK = 64'hFFFF_FFFF_FFFF_F2FE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [NSEG-1:0][SEL_W-1:0]   seg_sel_i,
    input  logic [NSEG-1:0][BASE_W-1:0]  seg_base_i,
    input  logic [NSEG-1:0][LIM_W-1:0]   seg_limit_i,
    input  logic [NSEG-1:0][AR_W-1:0]    seg_ar_i,
    input  logic [FLG_W-1:0]             guest_flags_i,
    input  logic                         long_guest_i,
    input  logic                         efer_load_i,
    input  logic [63:0]                  efer_i,
    output logic                         done_o,
    output logic                         fail_o,
    output logic [CODE_W-1:0]            code_o
);
    st_e st_q, st_d;

    logic [NSEG-1:0][SEL_W-1:0]  sel_q;
    logic [NSEG-1:0][BASE_W-1:0] base_q;
    logic [NSEG-1:0][LIM_W-1:0]  lim_q;
    logic [NSEG-1:0][AR_W-1:0]   ar_q;
    logic                        v86_q, lng_q, eld_q;
    logic [63:0]                 efer_q;

    logic [NRULE:1]              viol;
    logic                        any_bad;
    logic [CODE_W-1:0]           first_code;

    gsc_rule_eval #(
        .ADDR_BITS      (ADDR_BITS),
        .EFER_RSVD_MASK (EFER_RSVD_MASK)
    ) u_rules (
        .sel       (sel_q),
        .base      (base_q),
        .limit     (lim_q),
        .ar        (ar_q),
        .v86       (v86_q),
        .lng       (lng_q),
        .efer_load (eld_q),
        .efer      (efer_q),
        .viol      (viol)
    );

    gsc_prio_enc u_prio (
        .viol (viol),
        .any  (any_bad),
        .code (first_code)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_CHECK;
            ST_CHECK:  st_d = ST_REPORT;
            ST_REPORT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            base_q <= '0;
            lim_q  <= '0;
            ar_q   <= '0;
            v86_q  <= 1'b0;
            lng_q  <= 1'b0;
            eld_q  <= 1'b0;
            efer_q <= '0;
            done_o <= 1'b0;
            fail_o <= 1'b0;
            code_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        sel_q  <= seg_sel_i;
                        base_q <= seg_base_i;
                        lim_q  <= seg_limit_i;
                        ar_q   <= seg_ar_i;
                        v86_q  <= guest_flags_i[FLG_V86_BIT];
                        lng_q  <= long_guest_i;
                        eld_q  <= efer_load_i;
                        efer_q <= efer_i;
                    end
                end
                ST_CHECK: begin
                    done_o <= 1'b1;
                    fail_o <= any_bad;
                    code_o <= first_code;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gsc_sva.sv
module gsc_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] st,
    input logic       done,
    input logic       fail,
    input logic [4:0] code,
    input logic       v86,
    input logic       lng
);
    localparam logic [1:0] IDLE = 2'd0;

    AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IDLE && start) |=> ##1 done); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IDLE && !start) |=> !done); // R1
    AST_FAIL_CODE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail == (code != 5'd0))); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IDLE && !start) |=> ($stable(fail) && $stable(code))); // R2
    AST_MODE_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && v86 && lng) |-> (code == 5'd1)); // R3
    AST_CODE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code <= 5'd11)); // R12
endmodule

bind guest_seg_checker gsc_sva u_sva (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .st    (st_q),
    .done  (done_o),
    .fail  (fail_o),
    .code  (code_o),
    .v86   (v86_q),
    .lng   (lng_q)
);

// File: tb/sim_guest_seg_checker.sv
`timescale 1ns/1ps
module sim_guest_seg_checker;
    localparam logic [63:0] RSVD = 64'hFFFF_FFFF_FFFF_F2FE;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0][15:0] sel;
    logic [7:0][63:0] base;
    logic [7:0][31:0] lim;
    logic [7:0][31:0] ar;
    logic [63:0] flags;
    logic lng, eld;
    logic [63:0] efer;
    logic done, fail;
    logic [4:0] code;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    guest_seg_checker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .seg_sel_i(sel), .seg_base_i(base), .seg_limit_i(lim), .seg_ar_i(ar),
        .guest_flags_i(flags), .long_guest_i(lng), .efer_load_i(eld), .efer_i(efer),
        .done_o(done), .fail_o(fail), .code_o(code)
    );

    function automatic string rtag(int c);
        case (c)
            0: return "R2";   1: return "R3";   2: return "R4";  3: return "R4";
            4: return "R5";   5: return "R5";   6: return "R6";  7: return "R7";
            8: return "R8";   9: return "R9";  10: return "R10"; 11: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic bit is_canon(logic [63:0] a);
        logic signed [63:0] s;
        s = $signed(a) >>> 47;
        return (s == 0) || (s == -1);
    endfunction

    // Expected code derived from the requirement list, smallest code first (R12)
    function automatic int expect_code();
        bit v, lu, su, du, eu;
        v  = flags[17];
        lu = !ar[7][16]; su = !ar[1][16]; du = !ar[2][16]; eu = !ar[3][16];
        if (v && lng) return 1;
        if (eld && ((efer & RSVD) != 0)) return 2;
        if (eld && (efer[8] != lng || efer[10] != lng)) return 3;
        if (sel[6][2]) return 4;
        if (lu && sel[7][2]) return 5;
        if (!v && sel[1][1:0] != sel[0][1:0]) return 6;
        if (v) for (int i = 0; i < 6; i++) if (base[i] != 64'(sel[i]) * 16) return 7;
        if (!is_canon(base[4]) || !is_canon(base[5]) || !is_canon(base[6])
            || (lu && !is_canon(base[7]))) return 8;
        if (base[0] >= 64'h1_0000_0000 || (su && base[1] >= 64'h1_0000_0000)
            || (du && base[2] >= 64'h1_0000_0000) || (eu && base[3] >= 64'h1_0000_0000)) return 9;
        if (v) for (int i = 0; i < 6; i++) if (lim[i] != 32'hFFFF) return 10;
        if (v) for (int i = 0; i < 6; i++) if (ar[i] != 32'hF3) return 11;
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic baseline(bit v, bit l, bit e);
        for (int i = 0; i < 8; i++) begin
            sel[i]  = 16'h1000 + 16'(i * 32);
            base[i] = 64'(sel[i]) * 16;
            lim[i]  = 32'hFFFF;
            ar[i]   = 32'hF3;
        end
        base[6] = 64'hFFFF_8000_0000_2000;
        base[7] = 64'h0000_7FFF_0000_1000;
        ar[6]   = 32'h8B;
        ar[7]   = 32'h82;
        flags   = v ? 64'h2_0002 : 64'h2;
        lng     = l;
        eld     = e;
        efer    = 64'h800 | (l ? 64'h500 : 64'h0);
    endtask

    task automatic inject(int m);
        if (m[0])  efer[1]  = 1'b1;
        if (m[1])  efer[8]  = ~efer[8];
        if (m[2])  sel[6][2] = 1'b1;
        if (m[3])  sel[7][2] = 1'b1;
        if (m[4])  ar[7][16] = 1'b1;
        if (m[5])  sel[1][0] = ~sel[1][0];
        if (m[6])  base[2] = base[2] + 64'd16;
        if (m[7])  base[4] = 64'h0000_8000_0000_0000;
        if (m[8])  base[3][40] = 1'b1;
        if (m[9])  ar[3][16] = 1'b1;
        if (m[10]) lim[5] = 32'hF_FFFF;
        if (m[11]) ar[1] = 32'h93;
    endtask

    // start at one negedge, sample at the negedge after done rises
    task automatic run_one();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < WDOG; c++) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int e;
        baseline(0, 0, 0);
        repeat (3) @(negedge clk);
        check(done == 0, "R2", "reset done", int'(done), 0);
        check(fail == 0, "R2", "reset fail", int'(fail), 0);
        check(code == 0, "R2", "reset code", int'(code), 0);
        rst_n = 1'b1;

        // R1: capture at start, late start and input changes ignored, one-cycle done
        baseline(1, 0, 1); inject(12'h400);
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        baseline(0, 0, 1); inject(12'h004);
        @(negedge clk); start = 1'b0;
        check(done == 1, "R1", "done after one cycle", int'(done), 1);
        check(code == 10, "R1", "captured image used", int'(code), 10);
        @(negedge clk);
        check(done == 0, "R1", "done single cycle", int'(done), 0);
        @(negedge clk);
        check(done == 0, "R1", "start during CHECK ignored", int'(done), 0);
        check(code == 10 && fail == 1, "R2", "result held in IDLE", int'(code), 10);

        // clean passes
        baseline(0, 1, 1); run_one();
        check(fail == 0 && code == 0, "R2", "pass 64-bit", int'(code), 0);
        baseline(1, 0, 1); run_one();
        check(fail == 0 && code == 0, "R2", "pass v86", int'(code), 0);

        // main sweep: all mode combinations x all injection subsets
        for (int md = 0; md < 8; md++) begin
            for (int m = 0; m < 4096; m++) begin
                baseline(md[0], md[1], md[2]);
                inject(m);
                e = expect_code();
                run_one();
                if (!(done == 1 && code == 5'(e) && fail == (e != 0))) begin
                    n_tests++; n_fail++;
                    $display("FAIL %s R12 mode=%0d inj=%03h: actual %0d expected %0d",
                             rtag(e), md, m, int'(code), e);
                end else n_tests++;
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule